// File: doc/BRIEF.md
# SPI Serial Flash Command Front End

This block is the slave-side command logic of a serial flash device. It oversamples the SPI pins (clock, active-low select, data in) with the system clock. It collects an 8-bit opcode, most significant bit first, after select falls. The opcode is decoded with bit 3 treated as don't care. Address and data bits that follow the opcode go into an argument shift register. A command that changes state takes effect when select rises, and only if the number of serial clocks in the frame is exactly the length that command needs.

The block holds a write enable latch and a small status byte: protect-enable, two block-protect bits, write-enable and busy. Program, sector erase, chip erase and status write are write-class commands. They are accepted only while the latch is set. An accepted one starts a busy period of `WR_CYCLES` system clocks, and the latch clears when that period ends. Array program and erase are not performed here. They appear as one-cycle request pulses, with the address and data byte on side outputs, for an external array controller. Status read and ID read return bytes on the serial output, updated after each falling serial clock.

Top module: `spif_front`

## Requirements
- R1: After reset the status byte reads 0x00, `spi_miso` is 0 and no request pulse is issued.
- R2: Opcodes are decoded with bit 3 ignored. For example, 0x0E acts exactly as 0x06 (set write enable).
- R3: An 8-clock frame with opcode 0000x110 sets the write enable latch (status bit 1). An 8-clock frame with 0000x100 clears it, whatever the level of `wp_n`.
- R4: A write-class frame (program 0000x010, sector erase 0101x010, chip erase 0110x010, status write 0000x001) received while the latch is clear produces no request and leaves the status byte unchanged.
- R5: After opcode 0000x101, the serial output returns the status byte MSB first, repeated for every further byte while select stays low. The layout is: bit 7 protect-enable, bits 6..4 zero, bits 3..2 block-protect, bit 1 write-enable, bit 0 busy.
- R6: After opcode 0001x101, the serial output returns `MFR_ID`, then `DEV_ID`, then zero bytes.
- R7: A status write frame of 16 clocks, with the latch set, copies data bit 7 to protect-enable and data bits 3..2 to block-protect, and starts a busy period.
- R8: With the latch set, program (40 clocks: opcode, 24-bit address, data byte), sector erase (32 clocks: opcode, address) and chip erase (8 clocks) each raise exactly one one-cycle pulse on their own request output. The address and data appear on `req_addr`/`req_data` in that same cycle.
- R9: An accepted write-class command holds status bit 0 at 1 for exactly `WR_CYCLES` clocks. The write enable latch clears when the busy period ends.
- R10: While busy, every opcode except status read is ignored. Latch commands have no effect, and ID read drives 0 on `spi_miso`.
- R11: A frame whose clock count differs from the command's required length when select rises is aborted with no effect.
- R12: A status write is rejected, and the latch stays set, when protect-enable is 1 and `wp_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data out, registered |
| prog_req | output | 1 | One-cycle program request |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| req_addr | output | ADDR_W | Address of the program or sector erase request |
| req_data | output | DATA_W | Data byte of the program request |

## Verification
Each pin passes two synchronizer flops and one edge register, so a request pulse arrives about four clocks after select rises. A new `spi_miso` bit arrives about four clocks after a falling serial clock. The bench runs the serial clock at eight system clocks per half period. It samples `spi_miso` at the end of each low phase and waits 24 clocks after select rises before it starts another frame, so every result has settled before it is checked. A scoreboard monitor matches every request pulse against the queue of expected requests, in the cycle the pulse appears. Busy-phase tests use a 2000-clock write time, so several complete frames fit inside one busy period.

// File: rtl/spif_pkg.sv
package spif_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR,
    OP_READ, OP_PROG, OP_SERASE, OP_CERASE, OP_RDID
  } op_e;

  localparam int unsigned OPC_W = 8;

  // bit 3 is masked before comparison
  function automatic op_e decode_op(input logic [OPC_W-1:0] raw);
    logic [OPC_W-1:0] m;
    m = raw & 8'hF7;
    case (m)
      8'h06:   return OP_WREN;
      8'h04:   return OP_WRDI;
      8'h05:   return OP_RDSR;
      8'h01:   return OP_WRSR;
      8'h03:   return OP_READ;
      8'h02:   return OP_PROG;
      8'h52:   return OP_SERASE;
      8'h62:   return OP_CERASE;
      8'h15:   return OP_RDID;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spif_shifter.sv
module spif_shifter #(
  parameter int unsigned ARG_W = 32,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             cs_act,
  output logic             cs_end,
  output logic             sclk_fall,
  output logic [CNT_W-1:0] bitcnt,
  output logic [7:0]       opcode,
  output logic [ARG_W-1:0] arg
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] OPC_LEN = CNT_W'(8);

  logic [SYNC_N-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;
  logic sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_N-2:0], sclk};
      cs_s   <= {cs_s[SYNC_N-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_N-2:0], mosi};
      sclk_d <= sclk_s[SYNC_N-1];
      cs_d   <= cs_s[SYNC_N-1];
    end
  end

  assign cs_act    = ~cs_s[SYNC_N-1];
  assign cs_end    = cs_s[SYNC_N-1] & ~cs_d;
  assign sclk_rise = cs_act & sclk_s[SYNC_N-1] & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_s[SYNC_N-1] & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt <= '0;
      opcode <= '0;
      arg    <= '0;
    end else if (!cs_act) begin
      bitcnt <= '0;
    end else if (sclk_rise) begin
      if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
      if (bitcnt < OPC_LEN) opcode <= {opcode[6:0], mosi_s[SYNC_N-1]};
      else                  arg    <= {arg[ARG_W-2:0], mosi_s[SYNC_N-1]};
    end
  end

  // R11
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> bitcnt == '0);

endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl
  import spif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned WR_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_end,
  input  logic [CNT_W-1:0]        bitcnt,
  input  op_e                     op,
  input  logic [ADDR_W+DATA_W-1:0] arg,
  input  logic                    wp_n,
  output logic [7:0]              status,
  output logic                    busy,
  output logic                    prog_req,
  output logic                    se_req,
  output logic                    ce_req,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [DATA_W-1:0]       req_data
);
  localparam int unsigned BW = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LEN_OP   = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_WRSR = CNT_W'(8 + DATA_W);
  localparam logic [CNT_W-1:0] LEN_SE   = CNT_W'(8 + ADDR_W);
  localparam logic [CNT_W-1:0] LEN_PROG = CNT_W'(8 + ADDR_W + DATA_W);
  localparam logic [BW-1:0]    BUSY_INIT = BW'(WR_CYCLES);

  logic          wel, wpen;
  logic [1:0]    bp;
  logic [BW-1:0] bcnt;
  logic          wrsr_ok;

  assign wrsr_ok = ~(wpen & ~wp_n);
  assign status  = {wpen, 3'b000, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0; wpen <= 1'b0; bp <= '0;
      busy <= 1'b0; bcnt <= '0;
      prog_req <= 1'b0; se_req <= 1'b0; ce_req <= 1'b0;
      req_addr <= '0; req_data <= '0;
    end else begin
      prog_req <= 1'b0;
      se_req   <= 1'b0;
      ce_req   <= 1'b0;
      if (busy) begin
        if (bcnt == BW'(1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          bcnt <= '0;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end else if (cs_end) begin
        case (op)
          OP_WREN: if (bitcnt == LEN_OP) wel <= 1'b1;
          OP_WRDI: if (bitcnt == LEN_OP) wel <= 1'b0;
          OP_WRSR: if (bitcnt == LEN_WRSR && wel && wrsr_ok) begin
            wpen <= arg[7];
            bp   <= arg[3:2];
            busy <= 1'b1;
            bcnt <= BUSY_INIT;
          end
          OP_PROG: if (bitcnt == LEN_PROG && wel) begin
            prog_req <= 1'b1;
            req_addr <= arg[ADDR_W+DATA_W-1:DATA_W];
            req_data <= arg[DATA_W-1:0];
            busy     <= 1'b1;
            bcnt     <= BUSY_INIT;
          end
          OP_SERASE: if (bitcnt == LEN_SE && wel) begin
            se_req   <= 1'b1;
            req_addr <= arg[ADDR_W-1:0];
            busy     <= 1'b1;
            bcnt     <= BUSY_INIT;
          end
          OP_CERASE: if (bitcnt == LEN_OP && wel) begin
            ce_req <= 1'b1;
            busy   <= 1'b1;
            bcnt   <= BUSY_INIT;
          end
          default: ;
        endcase
      end
    end
  end

  // busy-length monitor for the check below
  logic [BW:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  // R8
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, se_req, ce_req}));

  // R4
  req_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_req || se_req || ce_req) |-> (busy && wel));

  // R9
  wel_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == (BW+1)'(WR_CYCLES));

endmodule

// File: rtl/spif_tx.sv
module spif_tx
  import spif_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h1F,
  parameter logic [7:0] DEV_ID = 8'h65
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       sclk_fall,
  input  logic       op_ready,
  input  op_e        op,
  input  logic       busy,
  input  logic [7:0] status,
  output logic       miso
);
  logic [2:0] bitpos;
  logic [1:0] byte_idx;
  logic       active;
  logic [7:0] tx_byte;

  assign active = op_ready & ((op == OP_RDSR) | ((op == OP_RDID) & ~busy));

  always_comb begin
    if (op == OP_RDSR)        tx_byte = status;
    else if (byte_idx == 2'd0) tx_byte = MFR_ID;
    else if (byte_idx == 2'd1) tx_byte = DEV_ID;
    else                       tx_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      miso     <= 1'b0;
      bitpos   <= '0;
      byte_idx <= '0;
    end else if (sclk_fall && op_ready) begin
      miso   <= active ? tx_byte[3'd7 - bitpos] : 1'b0;
      bitpos <= bitpos + 1'b1;
      if (bitpos == 3'd7 && byte_idx != 2'd2) byte_idx <= byte_idx + 1'b1;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && busy && op != OP_RDSR) |=> !miso);

endmodule

// File: rtl/spif_front.sv
module spif_front
  import spif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WR_CYCLES = 64,
  parameter logic [7:0]  MFR_ID    = 8'h1F,
  parameter logic [7:0]  DEV_ID    = 8'h65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              wp_n,
  output logic              spi_miso,
  output logic              prog_req,
  output logic              sect_erase_req,
  output logic              chip_erase_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  localparam int unsigned ARG_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(8 + ARG_W + 2);

  logic             cs_act, cs_end, sclk_fall, busy;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       opcode, status;
  logic [ARG_W-1:0] arg;
  op_e              op;
  logic             op_ready;

  assign op       = decode_op(opcode);
  assign op_ready = bitcnt >= CNT_W'(8);

  spif_shifter #(.ARG_W(ARG_W), .CNT_W(CNT_W), .SYNC_N(2)) u_shift (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .cs_act(cs_act), .cs_end(cs_end), .sclk_fall(sclk_fall),
    .bitcnt(bitcnt), .opcode(opcode), .arg(arg)
  );

  spif_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
              .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .cs_end(cs_end), .bitcnt(bitcnt), .op(op),
    .arg(arg), .wp_n(wp_n), .status(status), .busy(busy),
    .prog_req(prog_req), .se_req(sect_erase_req), .ce_req(chip_erase_req),
    .req_addr(req_addr), .req_data(req_data)
  );

  spif_tx #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .op_ready(op_ready), .op(op), .busy(busy), .status(status),
    .miso(spi_miso)
  );

endmodule

// File: tb/spif_front_tb_top.sv
`timescale 1ns/1ps
module spif_front_tb_top;
  localparam int WRC = 2000;
  localparam int HP  = 8;
  localparam logic [7:0] MFR = 8'h1F;
  localparam logic [7:0] DEV = 8'h65;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, preq, sreq, creq;
  logic [23:0] raddr;
  logic [7:0]  rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  spif_front #(.WR_CYCLES(WRC), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wp_n(wp_n), .spi_miso(miso), .prog_req(preq), .sect_erase_req(sreq),
    .chip_erase_req(creq), .req_addr(raddr), .req_data(rdata)
  );

  typedef struct { int kind; logic [23:0] addr; logic [7:0] data; } item_t;
  item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each request pulse with the queue head (R8, R4, R11)
  always @(negedge clk) begin
    if (!rst && (preq || sreq || creq)) begin
      int k;
      k = preq ? 1 : (sreq ? 2 : 3);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R11 unexpected request", k, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.kind == k, "R8 request kind", k, e.kind);
        if (k != 3) chk(e.addr == raddr, "R8 request address", raddr, e.addr);
        if (k == 1) chk(e.data == rdata, "R8 request data", rdata, e.data);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [63:0] tx, input int nbits,
                      output logic [63:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[nbits-1-i];
      wait_clk(HP);
      rx = {rx[62:0], miso};
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
    end
    wait_clk(HP);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(3*HP);
  endtask

  task automatic cmd(input logic [63:0] tx, input int nbits);
    logic [63:0] rx;
    xfer(tx, nbits, rx);
  endtask

  task automatic push(input int k, input logic [23:0] a, input logic [7:0] d);
    item_t e;
    e.kind = k; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  // status read: three repeated bytes after the opcode (R5)
  task automatic rdsr_check(input logic [7:0] exp, input string req);
    logic [63:0] rx;
    xfer({32'h0, 8'h05, 24'h0}, 32, rx);
    chk(rx[23:16] == exp, req, rx[23:16], exp);
    chk(rx[15:8] == exp && rx[7:0] == exp, "R5 repeated status", rx[15:0], {exp, exp});
  endtask

  initial begin
    logic [63:0] rx;
    wait_clk(5);
    chk(miso == 1'b0 && !preq && !sreq && !creq, "R1 reset outputs", miso, 0);
    rst = 1'b0;
    wait_clk(5);
    rdsr_check(8'h00, "R1 status after reset");

    // R4: write-class without latch
    cmd({24'h0, 8'h02, 24'h000100, 8'hAA}, 40);
    cmd({56'h0, 8'h62}, 8);
    cmd({48'h0, 8'h01, 8'h8C}, 16);
    rdsr_check(8'h00, "R4 dropped write leaves status");

    // R3
    cmd({56'h0, 8'h06}, 8);
    rdsr_check(8'h02, "R3 set latch");
    wp_n = 1'b0;
    cmd({56'h0, 8'h04}, 8);
    rdsr_check(8'h00, "R3 clear latch with wp_n low");
    wp_n = 1'b1;

    // R2: bit 3 set
    cmd({56'h0, 8'h0E}, 8);
    rdsr_check(8'h02, "R2 opcode bit3 ignored");

    // R11: wrong lengths
    cmd({48'h0, 8'h62, 8'h00}, 9);
    cmd({24'h0, 8'h02, 24'h001234, 8'h5}, 39);
    cmd({48'h0, 16'h0004}, 9);
    rdsr_check(8'h02, "R11 bad length aborted");

    // R8/R9/R10: program then busy behaviour
    push(1, 24'hABCDEF, 8'h5A);
    cmd({24'h0, 8'h02, 24'hABCDEF, 8'h5A}, 40);
    rdsr_check(8'h03, "R9 busy during write");
    cmd({56'h0, 8'h04}, 8);
    rdsr_check(8'h03, "R10 clear latch ignored while busy");
    xfer({40'h0, 8'h15, 16'h0}, 24, rx);
    chk(rx[15:0] == 16'h0, "R10 ID read ignored while busy", rx[15:0], 0);
    wait_clk(WRC);
    rdsr_check(8'h00, "R9 latch cleared after busy");

    // R6
    xfer({32'h0, 8'h15, 24'h0}, 32, rx);
    chk(rx[23:0] == {MFR, DEV, 8'h00}, "R6 ID bytes", rx[23:0], {MFR, DEV, 8'h00});

    // R8 sector erase (bit 3 set too) and chip erase
    cmd({56'h0, 8'h06}, 8);
    push(2, 24'h012000, 8'h00);
    cmd({32'h0, 8'h5A, 24'h012000}, 32);
    wait_clk(WRC);
    cmd({56'h0, 8'h06}, 8);
    push(3, 24'h0, 8'h0);
    cmd({56'h0, 8'h62}, 8);
    wait_clk(WRC);
    rdsr_check(8'h00, "R8 idle after erases");

    // R7
    cmd({56'h0, 8'h06}, 8);
    cmd({48'h0, 8'h01, 8'hFC}, 16);
    rdsr_check(8'h8F, "R7 status write busy");
    wait_clk(WRC);
    rdsr_check(8'h8C, "R7 status write result");

    // R12
    wp_n = 1'b0;
    cmd({56'h0, 8'h06}, 8);
    cmd({48'h0, 8'h01, 8'h00}, 16);
    rdsr_check(8'h8E, "R12 protected status write rejected");
    wp_n = 1'b1;
    cmd({48'h0, 8'h01, 8'h00}, 16);
    wait_clk(WRC);
    rdsr_check(8'h00, "R12 unprotected status write");

    wait_clk(20);
    chk(exp_q.size() == 0, "R8 all requests seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule